// File: doc/BRIEF.md
# Programmable Multi-Mode Timer Channel

One timer channel with a write port for a control word and a reload value, and a count value that can be read at any time. Each count step is enabled by one of several sources: the core clock divided by a power of two, synchronized rising edges of an external input, prescaled ticks qualified by an external gate level, or terminal-count pulses from a lower neighbouring channel. The counter counts up or down at a 16-bit or 32-bit width. At terminal count it pulses `tc_o`, and then either reloads or holds. It also sets a sticky interrupt flag, which software clears and which can be masked.

All logic runs on `clk_i`. The prescaler never stops counting and issues single-cycle enables, so no derived clocks are created. A write to address 0 updates the control word. A write to address 1 stores the reload value and also loads it into the counter. Control fields (bit positions in the control word): bit 15 run, bit 10 halt in debug, bit 9 interrupt clear (write-one action, not stored), bits 8:6 source select, bits 5:4 mode, bit 3 interrupt enable, bit 2 down, bit 1 wide (32-bit), bit 0 auto-reload.

Top module: `cfg_timer`

## Requirements
- R1: After reset `count_o`, `tc_o` and `irq_o` are 0, and the control word is all zero (stopped, up, 16-bit, no reload).
- R2: In mode 0, a source select s in 0..6 advances the counter exactly once every 2^s clock cycles. The prescaler never stops counting, so any window of k·2^s cycles holds exactly k steps.
- R3: In mode 0, source select 7 advances the counter once for each rising edge of `ext_clk_i`, after that edge passes a two-flop synchronizer.
- R4: Mode 1 counts prescaled ticks only while the synchronized `gate_i` is low. Mode 2 counts them only while it is high.
- R5: Mode 3 advances the counter once for each cycle in which `lower_tc_i` is high, whatever the source select holds.
- R6: Bit 2 = 1 counts down and 0 counts up. Bit 1 = 1 gives 32 bits. With bit 1 = 0, bits 31:16 of the count stay zero, and a loaded value is truncated to 16 bits.
- R7: Terminal count is zero when counting down and all ones at the selected width when counting up. `tc_o` is high for one cycle after the step that reaches it. The next step reloads the stored value when bit 0 = 1, and otherwise leaves the count unchanged.
- R8: The interrupt flag sets on each terminal-count step and stays set until a control write with bit 9 = 1 clears it. A set in the same cycle as a clear wins. `irq_o` shows the flag only while bit 3 = 1.
- R9: With bit 10 = 1 the count holds while `debug_i` is high. With bit 10 = 0, `debug_i` has no effect.
- R10: With bit 15 = 0 the count does not change except through a reload-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control word, 1 = reload value |
| wr_data_i | input | 32 | Write data |
| ext_clk_i | input | 1 | External count input, asynchronous |
| gate_i | input | 1 | External gate level, asynchronous |
| lower_tc_i | input | 1 | Terminal-count pulse from the lower channel, synchronous |
| debug_i | input | 1 | CPU debug state, synchronous |
| count_o | output | 32 | Current count value |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `debug_i` and `lower_tc_i` are synchronous to `clk_i`. They also assume that a reload value is never the terminal value itself, so two terminal-count pulses cannot follow each other back to back. The stimulus changes `ext_clk_i` and `gate_i` only at falling edges and holds each level for at least three cycles, so the synchronizer sees every level. Every check samples the count only after the synchronizer and edge-detect latency has passed. Reload values stay away from the terminal value, and every write occupies exactly one cycle.

// File: rtl/cfg_timer_pkg.sv
package cfg_timer_pkg;
  localparam int RUN_BIT  = 15;
  localparam int HALT_BIT = 10;
  localparam int CLR_BIT  = 9;
  localparam int SEL_LSB  = 6;
  localparam int SEL_W    = 3;
  localparam int MODE_LSB = 4;
  localparam int IE_BIT   = 3;
  localparam int DOWN_BIT = 2;
  localparam int WIDE_BIT = 1;
  localparam int RLD_BIT  = 0;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_GATE_LO = 2'd1,
    MODE_GATE_HI = 2'd2,
    MODE_CHAIN   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic             run;
    logic             dbg_halt;
    logic [SEL_W-1:0] src_sel;
    tmr_mode_e        mode;
    logic             irq_en;
    logic             down;
    logic             wide;
    logic             reload_en;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t decode_ctrl(input logic [15:0] w);
    tmr_ctrl_t c;
    c.run       = w[RUN_BIT];
    c.dbg_halt  = w[HALT_BIT];
    c.src_sel   = w[SEL_LSB +: SEL_W];
    c.mode      = tmr_mode_e'(w[MODE_LSB +: 2]);
    c.irq_en    = w[IE_BIT];
    c.down      = w[DOWN_BIT];
    c.wide      = w[WIDE_BIT];
    c.reload_en = w[RLD_BIT];
    return c;
  endfunction
endpackage

// File: rtl/cfg_timer_sync.sv
module cfg_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cfg_timer_presc.sv
module cfg_timer_presc #(
  parameter int SEL_W     = 3,
  parameter int DIV_STEPS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PW    = DIV_STEPS - 1;
  localparam int NSEL  = 2 ** SEL_W;
  localparam int PAD_W = NSEL - DIV_STEPS;

  logic [PW-1:0]        cnt_q;
  logic [DIV_STEPS-1:0] tick_vec;
  logic [NSEL-1:0]      tick_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_vec[0] = 1'b1;
  for (genvar k = 1; k < DIV_STEPS; k++) begin : g_div
    assign tick_vec[k] = &cnt_q[k-1:0];
  end

  assign tick_all = {{PAD_W{1'b0}}, tick_vec};
  assign tick_o   = tick_all[sel_i];

  AST_DIV2_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_W'(1) && $past(sel_i) == SEL_W'(1) && tick_o) |-> !$past(tick_o)); // R2
endmodule

// File: rtl/cfg_timer_core.sv
module cfg_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             wide_i,
  input  logic             reload_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_evt_o,
  output logic             tc_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask, term, cur, step_m;
  logic             at_term, tc_q;

  always_comb begin
    mask     = wide_i ? '1 : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    term     = down_i ? '0 : mask;
    cur      = cnt_q & mask;
    step_m   = (down_i ? cur - 1'b1 : cur + 1'b1) & mask;
    at_term  = (cur == term);
    tc_evt_o = !load_i && tick_i && !at_term && (step_m == term);
    cnt_d    = cur;
    if (load_i)       cnt_d = load_val_i & mask;
    else if (tick_i) begin
      if (!at_term)        cnt_d = step_m;
      else if (reload_en_i) cnt_d = reload_val_i & mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_evt_o;
    end
  end

  assign cnt_o = cnt_q;
  assign tc_o  = tc_q;

  AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> !tc_q); // R7
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> (cnt_q[CNT_W-1:HALF_W] == '0)); // R6
  AST_TC_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_evt_o |=> (cnt_q == $past(term))); // R7
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import cfg_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DIV_STEPS = 7,
  parameter int SYNC_N    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_clk_i,
  input  logic             gate_i,
  input  logic             lower_tc_i,
  input  logic             debug_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o,
  output logic             irq_o
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             irq_flag_q;
  logic             ext_s, ext_d_q, ext_rise, gate_s;
  logic             presc_tick, src_tick, tick, halt;
  logic             ctrl_wr, load_wr, irq_clr, tc_evt;

  assign ctrl_wr = wr_i && !wr_addr_i;
  assign load_wr = wr_i &&  wr_addr_i;
  assign irq_clr = ctrl_wr && wr_data_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q   <= decode_ctrl(wr_data_i[15:0]);
      if (load_wr) reload_q <= wr_data_i;
    end
  end

  cfg_timer_sync #(.STAGES(SYNC_N)) u_sync_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .q_o(ext_s));
  cfg_timer_sync #(.STAGES(SYNC_N)) u_sync_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d_q <= 1'b0;
    else         ext_d_q <= ext_s;
  end
  assign ext_rise = ext_s && !ext_d_q;

  cfg_timer_presc #(.SEL_W(SEL_W), .DIV_STEPS(DIV_STEPS)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(ctrl_q.src_sel), .tick_o(presc_tick));

  // source select 7 means external edges; otherwise prescaled ticks
  always_comb begin
    logic base;
    base = (ctrl_q.src_sel == '1) ? ext_rise : presc_tick;
    unique case (ctrl_q.mode)
      MODE_FREE:    src_tick = base;
      MODE_GATE_LO: src_tick = base && !gate_s;
      MODE_GATE_HI: src_tick = base &&  gate_s;
      MODE_CHAIN:   src_tick = lower_tc_i;
      default:      src_tick = 1'b0;
    endcase
  end

  assign halt = ctrl_q.dbg_halt && debug_i;
  assign tick = ctrl_q.run && !halt && src_tick;

  cfg_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .down_i       (ctrl_q.down),
    .wide_i       (ctrl_q.wide),
    .reload_en_i  (ctrl_q.reload_en),
    .load_i       (load_wr),
    .load_val_i   (wr_data_i),
    .reload_val_i (reload_q),
    .cnt_o        (count_o),
    .tc_evt_o     (tc_evt),
    .tc_o         (tc_o)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_flag_q <= 1'b0;
    else if (tc_evt)  irq_flag_q <= 1'b1;
    else if (irq_clr) irq_flag_q <= 1'b0;
  end

  assign irq_o = irq_flag_q && ctrl_q.irq_en;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_q && !irq_clr) |=> irq_flag_q); // R8
  AST_IRQ_FOLLOWS_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> irq_flag_q); // R8
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_i) |=> $stable(count_o)); // R10
  AST_DEBUG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.dbg_halt && debug_i && !wr_i) |=> $stable(count_o)); // R9
  AST_CHAIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode == MODE_CHAIN && !lower_tc_i && !wr_i) |=> $stable(count_o)); // R5
endmodule

// File: tb/cfg_timer_bench.sv
`timescale 1ns/1ps
module cfg_timer_bench;
  localparam logic [31:0] C_RUN  = 32'h8000;
  localparam logic [31:0] C_HALT = 32'h0400;
  localparam logic [31:0] C_CLR  = 32'h0200;
  localparam logic [31:0] C_IE   = 32'h0008;
  localparam logic [31:0] C_DOWN = 32'h0004;
  localparam logic [31:0] C_WIDE = 32'h0002;
  localparam logic [31:0] C_RLD  = 32'h0001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ext_clk = 1'b0, gate = 1'b0, lower_tc = 1'b0, debug = 1'b0;
  logic [31:0] count;
  logic        tc, irq;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_timer u_cfg_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ext_clk_i(ext_clk), .gate_i(gate), .lower_tc_i(lower_tc), .debug_i(debug),
    .count_o(count), .tc_o(tc), .irq_o(irq));

  function automatic logic [31:0] sel(input int s);  return 32'(s) << 6; endfunction
  function automatic logic [31:0] mode(input int m); return 32'(m) << 4; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic wreg(input logic a, input logic [31:0] d);
    wr = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr = 1'b0; wr_data = '0;
  endtask

  task automatic delta(input string req, input int n, input logic [31:0] exp);
    logic [31:0] c0;
    c0 = count;
    wait_n(n);
    chk(req, count - c0, exp);
  endtask

  task automatic tc_count(input int n, output int k);
    k = 0;
    repeat (n) begin @(negedge clk); if (tc) k++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 prescale sweep
    for (int s = 0; s < 7; s++) begin
      wreg(1'b0, C_RUN | C_WIDE | sel(s));
      wreg(1'b1, 32'd0);
      wait_n(3);
      delta($sformatf("R2 sel%0d", s), 4 * (1 << s), 32'd4);
    end

    // R3 external edges
    wreg(1'b0, C_RUN | C_WIDE | sel(7));
    wreg(1'b1, 32'd0);
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; wait_n(3);
      ext_clk = 1'b0; wait_n(3);
    end
    wait_n(4);
    chk("R3 ext edges", count, 32'd5);

    // R4 gated modes
    wreg(1'b0, C_RUN | C_WIDE | sel(0) | mode(1));
    gate = 1'b0; wait_n(4);
    delta("R4 gate-lo open", 20, 32'd20);
    gate = 1'b1; wait_n(4);
    delta("R4 gate-lo shut", 20, 32'd0);
    wreg(1'b0, C_RUN | C_WIDE | sel(0) | mode(2));
    wait_n(2);
    delta("R4 gate-hi open", 20, 32'd20);
    gate = 1'b0; wait_n(4);
    delta("R4 gate-hi shut", 20, 32'd0);

    // R5 chained mode ignores prescaler
    wreg(1'b0, C_RUN | C_WIDE | sel(0) | mode(3));
    wreg(1'b1, 32'd0);
    for (int i = 0; i < 6; i++) begin
      lower_tc = 1'b1; wait_n(1);
      lower_tc = 1'b0; wait_n(2);
    end
    wait_n(2);
    chk("R5 chain pulses", count, 32'd6);

    // R7 down with reload 3: period 4
    wreg(1'b0, C_RUN | C_DOWN | C_RLD | sel(0));
    wreg(1'b1, 32'd3);
    tc_count(40, k);
    chk("R7 reload tc count", 32'(k), 32'd10);

    // R6/R7 narrow up, no reload, truncated load
    wreg(1'b0, C_RUN | sel(0));
    wreg(1'b1, 32'h0001_FFFD);
    chk("R6 narrow load", count, 32'h0000_FFFD);
    tc_count(20, k);
    chk("R7 single tc", 32'(k), 32'd1);
    chk("R7 hold at term", count, 32'h0000_FFFF);

    // R6 wide up
    wreg(1'b0, C_RUN | C_WIDE | sel(0));
    wreg(1'b1, 32'hFFFF_FFFA);
    wait_n(10);
    chk("R6 wide up term", count, 32'hFFFF_FFFF);

    // R6 wide down
    wreg(1'b0, C_RUN | C_WIDE | C_DOWN | sel(0));
    wreg(1'b1, 32'h0001_0005);
    wait_n(3);
    chk("R6 wide down", count, 32'h0001_0002);

    // R8 interrupt
    wreg(1'b0, C_RUN | C_IE | sel(0));
    wreg(1'b1, 32'h0000_FFFD);
    wait_n(10);
    chk("R8 irq set", 32'(irq), 1);
    wreg(1'b0, C_RUN | C_IE | sel(0) | C_CLR);
    wait_n(1);
    chk("R8 irq cleared", 32'(irq), 0);
    wreg(1'b0, C_RUN | C_IE | C_RLD | mode(3));
    wreg(1'b1, 32'h0000_FFFE);
    lower_tc = 1'b1;
    wreg(1'b0, C_RUN | C_IE | C_RLD | mode(3) | C_CLR);
    lower_tc = 1'b0;
    chk("R8 set beats clear", 32'(irq), 1);
    wreg(1'b0, C_RUN | C_RLD | mode(3));
    chk("R8 masked", 32'(irq), 0);
    wreg(1'b0, C_RUN | C_IE | C_RLD | mode(3));
    chk("R8 unmasked pending", 32'(irq), 1);

    // R9 debug halt
    wreg(1'b0, C_RUN | C_WIDE | C_HALT | sel(0));
    wreg(1'b1, 32'd0);
    debug = 1'b1; wait_n(1);
    delta("R9 halted", 10, 32'd0);
    debug = 1'b0; wait_n(1);
    delta("R9 resumed", 10, 32'd10);
    wreg(1'b0, C_RUN | C_WIDE | sel(0));
    debug = 1'b1; wait_n(1);
    delta("R9 no halt bit", 10, 32'd10);
    debug = 1'b0;

    // R10 stopped
    wreg(1'b0, C_WIDE | sel(0));
    wait_n(1);
    delta("R10 stopped", 10, 32'd0);
    wreg(1'b1, 32'd77);
    chk("R10 load while stopped", count, 32'd77);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule